// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a module clock into the bit-level timebase of one CAN node. A fixed divide-by-two stage feeds a programmable prescaler that produces one time-quantum tick every `2 x (prescale + 1)` clocks. Each bit is built from a one-quantum synchronisation segment, a first phase segment (TSEG1, which also holds the propagation delay) and a second phase segment (TSEG2). The block raises a transmit strobe when the sync quantum ends. It raises a sample strobe when TSEG1 ends, and at that point it captures the receive line as the bit value.

Each configuration field holds its quantum count minus one. The 10-bit prescale value is split into a 6-bit low field and a 4-bit high field. The fields are copied into internal registers only while the block is held in configuration mode and the update-unlock input is high. Releasing configuration mode starts bus timing at a fresh bit.

The block tracks falling (recessive-to-dominant) edges on the receive line. If the bus is idle, an edge restarts the bit. During a frame, one edge per bit shifts the bit boundary. An edge that is late lengthens TSEG1. An edge that is early shortens TSEG2 or ends it. The shift is never more than the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: After reset and while `init_mode` is high, `tq_tick`, `sample_stb` and `tx_stb` stay low and `seg_state` reads 0 (sync).
- R2: While running, `tq_tick` pulses for one clock every `2 x (64 x hi + lo + 1)` clocks, where hi is `cfg_brp_hi` and lo is `cfg_brp_lo`.
- R3: With no edges on `rx_in`, consecutive `tx_stb` pulses are `(1 + T1 + T2)` quanta apart, where T1 = `cfg_tseg1` + 1 and T2 = `cfg_tseg2` + 1. `seg_state` encodes sync = 0, TSEG1 = 1 and TSEG2 = 2.
- R4: `sample_stb` pulses on the tick that ends the last TSEG1 quantum, T1 quanta after `tx_stb` when no edge occurs. In the clock after the strobe, `sample_bit` holds the value `rx_in` had during the strobe.
- R5: `tx_stb` pulses on the tick that ends the sync quantum. The first pulse after `init_mode` falls comes `2 x (prescale + 1) - 1` clocks after the first running clock.
- R6: Configuration inputs take effect only if they are presented while `init_mode` and `cfg_unlock` are both high. Changes made at any other time do not alter the timing.
- R7: A falling edge on `rx_in` while `bus_idle` is high restarts the bit. The prescaler and the segment counter both clear, so the next `tx_stb` comes `2 x (prescale + 1)` clocks after the edge clock.
- R8: A falling edge during quantum q of TSEG1 (bus not idle) lengthens TSEG1 by min(q + 1, SJW) quanta, where SJW = `cfg_sjw` + 1.
- R9: A falling edge during quantum q of TSEG2 has a phase error of e = T2 - q. If e <= SJW, the bit restarts as in R7. Otherwise TSEG2 is shortened by SJW quanta.
- R10: Only the first edge in TSEG1 or TSEG2 of a bit is acted on. Later edges in the same bit are ignored until the next sync segment.
- R11: An edge in the same clock as the tick that would end TSEG1 is applied first. The sample strobe and the bit end move out by the extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Holds the block in configuration mode when high |
| cfg_unlock | input | 1 | Allows the configuration fields to be copied while in configuration mode |
| cfg_brp_lo | input | 6 | Prescale value, low part (value minus one) |
| cfg_brp_hi | input | 4 | Prescale value, high part (x64) |
| cfg_tseg1 | input | 4 | TSEG1 length in quanta minus one |
| cfg_tseg2 | input | 3 | TSEG2 length in quanta minus one |
| cfg_sjw | input | 2 | Jump width in quanta minus one |
| bus_idle | input | 1 | High when the frame logic sees an idle bus (hard sync allowed) |
| rx_in | input | 1 | Receive line, 1 = recessive |
| tq_tick | output | 1 | One-clock pulse at the end of each time quantum |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Receive value captured at the last sample point |
| tx_stb | output | 1 | One-clock pulse at the end of the sync quantum |
| seg_state | output | 2 | Current segment: 0 sync, 1 TSEG1, 2 TSEG2 |

## Verification
Two events can fall in the same clock: a receive edge and the quantum tick that ends TSEG1. The bench forces this by dropping `rx_in` in exactly the tick clock of the last TSEG1 quantum. It then checks that the sample point and the next transmit strobe move out by the jump width rather than sampling on schedule. A second pairing is tested as well: an early edge in the last TSEG2 quantum against the tick that would enter sync. There the restart must override the tick, and the next transmit strobe is timed from the edge. A cycle-by-cycle reference model judges every strobe around both cases.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
    parameter int BRP_W = 10,
    parameter int T1_W  = 4,
    parameter int T2_W  = 3,
    parameter int SJ_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_mode,
    input  logic             cfg_unlock,
    input  logic [BRP_W-1:0] brp_in,
    input  logic [T1_W-1:0]  t1_in,
    input  logic [T2_W-1:0]  t2_in,
    input  logic [SJ_W-1:0]  sj_in,
    output logic [BRP_W-1:0] brp,
    output logic [T1_W-1:0]  t1,
    output logic [T2_W-1:0]  t2,
    output logic [SJ_W-1:0]  sj
);

    logic load;
    assign load = init_mode && cfg_unlock;

    always_ff @(posedge clk) begin
        if (rst) begin
            brp <= '0;
            t1  <= '0;
            t2  <= '0;
            sj  <= '0;
        end else if (load) begin
            brp <= brp_in;
            t1  <= t1_in;
            t2  <= t2_in;
            sj  <= sj_in;
        end
    end

    // R6: fields frozen unless both gates are open
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(brp) && $stable(t1) && $stable(t2) && $stable(sj)));

endmodule

// File: rtl/can_bt_prescale.sv
module can_bt_prescale #(
    parameter int BRP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);

    logic             half;
    logic [BRP_W-1:0] cnt;

    assign tick = run && half && (cnt == brp);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            half <= 1'b0;
            cnt  <= '0;
        end else begin
            half <= ~half;
            if (half) begin
                cnt <= (cnt == brp) ? '0 : cnt + BRP_W'(1);
            end
        end
    end

    // R2: quanta are at least two clocks long
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rx_in,
    output logic fall
);

    logic rx_prev;

    always_ff @(posedge clk) begin
        if (rst) rx_prev <= 1'b1;
        else     rx_prev <= rx_in;
    end

    assign fall = run && rx_prev && !rx_in;

endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg
    import can_bt_pkg::*;
#(
    parameter int T1_W = 4,
    parameter int T2_W = 3,
    parameter int SJ_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick,
    input  logic            fall,
    input  logic            bus_idle,
    input  logic            rx_in,
    input  logic [T1_W-1:0] t1,
    input  logic [T2_W-1:0] t2,
    input  logic [SJ_W-1:0] sj,
    output logic            restart,
    output logic            sample_stb,
    output logic            tx_stb,
    output logic            sample_bit,
    output logic [1:0]      seg_code
);

    localparam int QW = int'(max2(max2(T1_W, T2_W), SJ_W)) + 1;
    localparam int AW = SJ_W + 1;

    seg_e          seg, seg_n;
    logic [QW-1:0] q, q_n;
    logic [AW-1:0] ext, ext_n, cut, cut_n;
    logic          synced, synced_n;
    logic [QW-1:0] t1q, t2q, sjq_w, late, early;
    logic [AW-1:0] sjq;
    logic          ph1_end, ph2_end, adv;

    assign t1q   = QW'(t1) + QW'(1);
    assign t2q   = QW'(t2) + QW'(1);
    assign sjq   = AW'(sj) + AW'(1);
    assign sjq_w = QW'(sjq);
    assign late  = q + QW'(1);
    assign early = t2q - q;

    always_comb begin
        restart  = 1'b0;
        ext_n    = ext;
        cut_n    = cut;
        synced_n = synced;
        if (fall) begin
            if (bus_idle) begin
                restart = 1'b1;
            end else if (!synced) begin
                if (seg == SEG_PH1) begin
                    ext_n    = (late < sjq_w) ? AW'(late) : sjq;
                    synced_n = 1'b1;
                end else if (seg == SEG_PH2) begin
                    if (early <= sjq_w) begin
                        restart = 1'b1;
                    end else begin
                        cut_n    = sjq;
                        synced_n = 1'b1;
                    end
                end
            end
        end

        ph1_end    = (q == t1q + QW'(ext_n) - QW'(1));
        ph2_end    = (q == t2q - QW'(cut_n) - QW'(1));
        adv        = tick && !restart;
        sample_stb = adv && (seg == SEG_PH1) && ph1_end;
        tx_stb     = adv && (seg == SEG_SYNC);

        seg_n = seg;
        q_n   = q;
        if (!run || restart) begin
            seg_n    = SEG_SYNC;
            q_n      = '0;
            ext_n    = '0;
            cut_n    = '0;
            synced_n = 1'b0;
        end else if (tick) begin
            case (seg)
                SEG_SYNC: begin
                    seg_n = SEG_PH1;
                    q_n   = '0;
                end
                SEG_PH1: begin
                    if (ph1_end) begin
                        seg_n = SEG_PH2;
                        q_n   = '0;
                    end else begin
                        q_n = q + QW'(1);
                    end
                end
                default: begin
                    if (ph2_end) begin
                        seg_n    = SEG_SYNC;
                        q_n      = '0;
                        ext_n    = '0;
                        cut_n    = '0;
                        synced_n = 1'b0;
                    end else begin
                        q_n = q + QW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg        <= SEG_SYNC;
            q          <= '0;
            ext        <= '0;
            cut        <= '0;
            synced     <= 1'b0;
            sample_bit <= 1'b1;
        end else begin
            seg    <= seg_n;
            q      <= q_n;
            ext    <= ext_n;
            cut    <= cut_n;
            synced <= synced_n;
            if (sample_stb) sample_bit <= rx_in;
        end
    end

    assign seg_code = seg;

    // R8: lengthening never exceeds the jump width
    assert_ext_bound_R8: assert property (@(posedge clk) disable iff (rst)
        ext <= sjq);

    // R9: shortening never exceeds the jump width
    assert_cut_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cut <= sjq);

    // R7: idle-bus edge puts the bit back at sync
    assert_hard_sync_R7: assert property (@(posedge clk) disable iff (rst)
        (fall && bus_idle) |=> (seg == SEG_SYNC && q == '0));

    // R4: the sample point closes TSEG1
    assert_sample_ph2_R4: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && run) |=> (seg == SEG_PH2));

    // R10: a second edge in the same bit leaves the adjustment alone
    assert_one_sync_R10: assert property (@(posedge clk) disable iff (rst)
        (run && synced && fall && !bus_idle && !tick) |=> ($stable(ext) && $stable(cut)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BRP_LO_W = 6,
    parameter int BRP_HI_W = 4,
    parameter int TSEG1_W  = 4,
    parameter int TSEG2_W  = 3,
    parameter int SJW_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                init_mode,
    input  logic                cfg_unlock,
    input  logic [BRP_LO_W-1:0] cfg_brp_lo,
    input  logic [BRP_HI_W-1:0] cfg_brp_hi,
    input  logic [TSEG1_W-1:0]  cfg_tseg1,
    input  logic [TSEG2_W-1:0]  cfg_tseg2,
    input  logic [SJW_W-1:0]    cfg_sjw,
    input  logic                bus_idle,
    input  logic                rx_in,
    output logic                tq_tick,
    output logic                sample_stb,
    output logic                sample_bit,
    output logic                tx_stb,
    output logic [1:0]          seg_state
);

    localparam int BRP_W = BRP_LO_W + BRP_HI_W;

    logic [BRP_W-1:0]   brp;
    logic [TSEG1_W-1:0] t1;
    logic [TSEG2_W-1:0] t2;
    logic [SJW_W-1:0]   sj;
    logic               run, fall, restart;

    assign run = !init_mode;

    can_bt_cfg #(.BRP_W(BRP_W), .T1_W(TSEG1_W), .T2_W(TSEG2_W), .SJ_W(SJW_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .init_mode  (init_mode),
        .cfg_unlock (cfg_unlock),
        .brp_in     ({cfg_brp_hi, cfg_brp_lo}),
        .t1_in      (cfg_tseg1),
        .t2_in      (cfg_tseg2),
        .sj_in      (cfg_sjw),
        .brp        (brp),
        .t1         (t1),
        .t2         (t2),
        .sj         (sj)
    );

    can_bt_prescale #(.BRP_W(BRP_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .brp     (brp),
        .tick    (tq_tick)
    );

    can_bt_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .rx_in (rx_in),
        .fall  (fall)
    );

    can_bt_seg #(.T1_W(TSEG1_W), .T2_W(TSEG2_W), .SJ_W(SJW_W)) u_seg (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (tq_tick),
        .fall       (fall),
        .bus_idle   (bus_idle),
        .rx_in      (rx_in),
        .t1         (t1),
        .t2         (t2),
        .sj         (sj),
        .restart    (restart),
        .sample_stb (sample_stb),
        .tx_stb     (tx_stb),
        .sample_bit (sample_bit),
        .seg_code   (seg_state)
    );

    // R1: configuration mode is silent
    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        init_mode |-> (!tq_tick && !sample_stb && !tx_stb));

endmodule

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_mode = 1'b1;
    logic       cfg_unlock = 1'b0;
    logic [5:0] cfg_brp_lo = '0;
    logic [3:0] cfg_brp_hi = '0;
    logic [3:0] cfg_tseg1 = '0;
    logic [2:0] cfg_tseg2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic       tq_tick, sample_stb, sample_bit, tx_stb;
    logic [1:0] seg_state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_unlock(cfg_unlock),
        .cfg_brp_lo(cfg_brp_lo), .cfg_brp_hi(cfg_brp_hi), .cfg_tseg1(cfg_tseg1),
        .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw), .bus_idle(bus_idle), .rx_in(rx_in),
        .tq_tick(tq_tick), .sample_stb(sample_stb), .sample_bit(sample_bit),
        .tx_stb(tx_stb), .seg_state(seg_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_brp, m_t1, m_t2, m_sj, m_h, m_pc, m_seg, m_q, m_ext, m_cut, m_sync;
    bit m_rxp, m_sbit, m_ok = 1'b0;
    bit r_run, r_tick, r_fall, r_rs, r_samp, r_tx;
    int n_ext, n_cut, n_sync;

    always @(negedge clk) begin
        if (rst) begin
            m_brp = 0; m_t1 = 1; m_t2 = 1; m_sj = 1;
            m_h = 0; m_pc = 0; m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_sync = 0;
            m_rxp = 1'b1; m_sbit = 1'b1; m_ok = 1'b1;
        end else if (m_ok) begin
            r_run  = !init_mode;
            r_tick = r_run && (m_h == 1) && (m_pc == m_brp);
            r_fall = r_run && m_rxp && !rx_in;
            r_rs = 1'b0; n_ext = m_ext; n_cut = m_cut; n_sync = m_sync;
            if (r_fall) begin
                if (bus_idle) r_rs = 1'b1;
                else if (m_sync == 0 && m_seg == 1) begin
                    n_ext = (m_q + 1 < m_sj) ? m_q + 1 : m_sj;
                    n_sync = 1;
                end else if (m_sync == 0 && m_seg == 2) begin
                    if (m_t2 - m_q <= m_sj) r_rs = 1'b1;
                    else begin n_cut = m_sj; n_sync = 1; end
                end
            end
            r_samp = r_tick && !r_rs && m_seg == 1 && (m_q == m_t1 + n_ext - 1);
            r_tx   = r_tick && !r_rs && m_seg == 0;
            chk(tq_tick === r_tick, "R2 tq_tick", int'(tq_tick), int'(r_tick));
            chk(sample_stb === r_samp, "R4 sample_stb", int'(sample_stb), int'(r_samp));
            chk(tx_stb === r_tx, "R5 tx_stb", int'(tx_stb), int'(r_tx));
            chk(sample_bit === m_sbit, "R4 sample_bit", int'(sample_bit), int'(m_sbit));
            chk(int'(seg_state) == m_seg, "R3 seg_state", int'(seg_state), m_seg);
            if (r_samp) m_sbit = rx_in;
            m_rxp = rx_in;
            if (!r_run || r_rs) begin
                m_h = 0; m_pc = 0;
                m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_sync = 0;
            end else begin
                if (m_h == 1) m_pc = (m_pc == m_brp) ? 0 : m_pc + 1;
                m_h = 1 - m_h;
                m_ext = n_ext; m_cut = n_cut; m_sync = n_sync;
                if (r_tick) begin
                    if (m_seg == 0) begin m_seg = 1; m_q = 0; end
                    else if (m_seg == 1) begin
                        if (m_q == m_t1 + m_ext - 1) begin m_seg = 2; m_q = 0; end
                        else m_q++;
                    end else begin
                        if (m_q == m_t2 - m_cut - 1) begin
                            m_seg = 0; m_q = 0; m_ext = 0; m_cut = 0; m_sync = 0;
                        end else m_q++;
                    end
                end
            end
            if (init_mode && cfg_unlock) begin
                m_brp = int'(cfg_brp_hi) * 64 + int'(cfg_brp_lo);
                m_t1 = int'(cfg_tseg1) + 1;
                m_t2 = int'(cfg_tseg2) + 1;
                m_sj = int'(cfg_sjw) + 1;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_tx(output int t);
        do @(negedge clk); while (tx_stb !== 1'b1);
        t = cyc;
    endtask

    task automatic wait_samp(output int t);
        do @(negedge clk); while (sample_stb !== 1'b1);
        t = cyc;
    endtask

    task automatic wait_tick(output int t);
        do @(negedge clk); while (tq_tick !== 1'b1);
        t = cyc;
    endtask

    task automatic configure(input int lo, input int hi, input int s1, input int s2,
                             input int sw, output int c0);
        step(1);
        init_mode = 1'b1; cfg_unlock = 1'b1;
        cfg_brp_lo = 6'(lo); cfg_brp_hi = 4'(hi);
        cfg_tseg1 = 4'(s1); cfg_tseg2 = 3'(s2); cfg_sjw = 2'(sw);
        step(1);
        cfg_unlock = 1'b0;
        step(1);
        init_mode = 1'b0;
        c0 = cyc;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int t0, t1, ts, c0, quiet;

    initial begin
        step(4);
        rst = 1'b0;
        // R1: quiet while held in configuration mode
        quiet = 0;
        repeat (20) begin
            @(negedge clk);
            if (tq_tick || sample_stb || tx_stb) quiet++;
        end
        chk(quiet == 0, "R1 strobes in init", quiet, 0);
        chk(seg_state == 2'd0, "R1 seg_state in init", int'(seg_state), 0);

        // prescale 2, T1=8, T2=4, SJW=4 ; receive line held dominant
        rx_in = 1'b0;
        configure(1, 0, 7, 3, 3, c0);
        wait_tx(t0);
        chk(t0 - c0 == 3, "R5 first tx_stb offset", t0 - c0, 3);
        wait_samp(ts);
        chk(ts - t0 == 32, "R4 sample offset", ts - t0, 32);
        @(negedge clk);
        chk(sample_bit == 1'b0, "R4 sample_bit dominant", int'(sample_bit), 0);
        step(1);
        rx_in = 1'b1;
        wait_tx(t1);
        chk(t1 - t0 == 52, "R3 nominal bit length", t1 - t0, 52);

        // R8: late edge in TSEG1 quantum 1
        wait_tx(t0);
        step(6);  rx_in = 1'b0;
        step(14); rx_in = 1'b1;
        wait_tx(t1);
        chk(t1 - t0 == 60, "R8 TSEG1 lengthened by 2", t1 - t0, 60);

        // R10: second edge in the same bit is ignored
        t0 = t1;
        step(6); rx_in = 1'b0;
        step(4); rx_in = 1'b1;
        step(4); rx_in = 1'b0;
        step(4); rx_in = 1'b1;
        wait_tx(t1);
        chk(t1 - t0 == 60, "R10 one resync per bit", t1 - t0, 60);

        // R11: edge in the tick clock ending TSEG1
        t0 = t1;
        step(32); rx_in = 1'b0;
        wait_samp(ts);
        chk(ts - t0 == 48, "R11 sample moved by SJW", ts - t0, 48);
        step(1); rx_in = 1'b1;
        wait_tx(t1);
        chk(t1 - t0 == 68, "R11 bit lengthened by SJW", t1 - t0, 68);

        // R7: hard sync on idle bus
        bus_idle = 1'b1;
        wait_tx(t0);
        step(10); rx_in = 1'b0;
        wait_tx(t1);
        chk(t1 - t0 == 14, "R7 hard sync restart", t1 - t0, 14);
        step(2); rx_in = 1'b1; bus_idle = 1'b0;

        // R9: SJW=2, early edges in TSEG2
        configure(1, 0, 7, 3, 1, c0);
        wait_tx(t0);
        step(34); rx_in = 1'b0;
        step(6);  rx_in = 1'b1;
        wait_tx(t1);
        chk(t1 - t0 == 44, "R9 TSEG2 shortened by SJW", t1 - t0, 44);
        t0 = t1;
        step(46); rx_in = 1'b0;
        wait_tx(t1);
        chk(t1 - t0 == 50, "R9 small error restarts bit", t1 - t0, 50);
        step(2); rx_in = 1'b1;

        // R2: prescale split across both fields (69 -> 140 clocks)
        configure(5, 1, 1, 0, 0, c0);
        wait_tick(t0);
        wait_tick(t1);
        chk(t1 - t0 == 140, "R2 quantum period", t1 - t0, 140);
        wait_tx(t0);
        wait_tx(t1);
        chk(t1 - t0 == 560, "R3 bit length 4 quanta", t1 - t0, 560);

        // R6: fields changed without unlock do not apply
        step(1);
        init_mode = 1'b1;
        cfg_brp_lo = 6'd0; cfg_brp_hi = 4'd0; cfg_tseg1 = 4'd5;
        step(1);
        init_mode = 1'b0;
        wait_tx(t0);
        wait_tx(t1);
        chk(t1 - t0 == 560, "R6 locked fields ignored", t1 - t0, 560);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule